// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Controller

This block adds automatic hardware handshaking to one UART channel whose receive FIFO holds 32 entries. On the receive side it compares the FIFO fill count with a set of four trigger levels, chosen by a 2-bit select. It raises a receive-threshold interrupt when the fill reaches the selected level. It drives RTS with hysteresis: RTS goes high (stop) one trigger level above the selected one, and goes low again only once the fill has drained below the level beneath the selected one.

On the transmit side the CTS pin passes through a two-flop synchronizer. The result sets a transmit-permit signal, and that signal is re-evaluated only on the strobe that marks the point before the transmitter loads its next character. A character that is already being shifted out is never cut short. When automatic RTS is off, RTS follows the software modem-control value. When automatic CTS is off, transmission is always permitted. The FIFO storage and the serial shifters are outside this block.

Top module: `uart_hs_flow`

## Requirements
- R1: Under reset and directly after it, tx_permit_o is 1 and rx_irq_o is 0, and rts_o equals sw_rts_i while auto_rts_en_i is 0.
- R2: Trigger select values 0, 1, 2 and 3 give levels DEPTH/4, DEPTH/2, 3*DEPTH/4 and DEPTH-DEPTH/8 (8, 16, 24 and 28 for DEPTH=32). While auto_rts_en_i is 1 and rx_count_i is at or above the selected level, rx_irq_o is 1 from the next clock edge.
- R3: rx_irq_o is 0 from the next clock edge whenever rx_count_i is below the selected level or auto_rts_en_i is 0.
- R4: While auto_rts_en_i is 1 and rx_count_i is at or above the upper threshold, rts_o is 1 from the next clock edge. The upper threshold is the next trigger level above the selected one, or DEPTH (full) for select 3.
- R5: While auto_rts_en_i is 1, rts_o returns to 0 from the next edge only when rx_count_i is below the lower threshold. The lower threshold is the trigger level just beneath the selected one, or 1 (empty) for select 0. Between the two thresholds rts_o keeps its value.
- R6: While auto_rts_en_i is 0, rts_o equals sw_rts_i and the stop state is cleared. When automatic RTS is then enabled, rts_o is 0 until a threshold is crossed.
- R7: With auto_cts_en_i at 1, a clock edge at which tx_boundary_i is 1 loads tx_permit_o with the inverse of CTS as delayed by two synchronizer flops. A change of cts_i reaches tx_permit_o no earlier than the third edge after it.
- R8: While auto_cts_en_i is 0, tx_permit_o is 1 from the next clock edge, whatever cts_i is.
- R9: With auto_cts_en_i at 1, tx_permit_o does not change at edges where tx_boundary_i is 0, whatever cts_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| auto_cts_en_i | input | 1 | Enable automatic CTS gating |
| auto_rts_en_i | input | 1 | Enable automatic RTS and threshold interrupt |
| trig_sel_i | input | 2 | Receive trigger level select |
| rx_count_i | input | $clog2(DEPTH+1) | Receive FIFO fill count |
| sw_rts_i | input | 1 | Software RTS value used when automatic RTS is off |
| cts_i | input | 1 | CTS pin, asynchronous, 1 = stop |
| tx_boundary_i | input | 1 | Strobe: transmitter about to load the next character |
| rts_o | output | 1 | RTS pin, 1 = stop |
| tx_permit_o | output | 1 | Transmitter may start the next character |
| rx_irq_o | output | 1 | Receive-threshold interrupt request |

## Verification
The bench builds the block with the default DEPTH of 32, which gives a 6-bit fill count. For each of the four trigger selects it ramps the count through every value from 0 to 32 and back down. This reaches both hysteresis thresholds, including the full-FIFO upper threshold of select 3 and the empty lower threshold of select 0. The CTS path is driven with and without boundary strobes, which exposes the synchronizer latency edge by edge.

// File: rtl/uart_hs_pkg.sv
package uart_hs_pkg;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned NUM_LVL = 1 << SEL_W;

  // idx 0..3 -> ordered trigger levels for a FIFO of the given depth
  function automatic int unsigned trig_lvl(int unsigned depth, int unsigned idx);
    case (idx)
      0:       return depth / 4;
      1:       return depth / 2;
      2:       return (3 * depth) / 4;
      default: return depth - depth / 8;
    endcase
  endfunction
endpackage

// File: rtl/uart_hs_sync.sv
module uart_hs_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_hs_rts.sv
module uart_hs_rts
  import uart_hs_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             sw_rts_i,
  output logic             rts_o,
  output logic             irq_o
);
  localparam int unsigned TAB_N = NUM_LVL + 2;

  // [0]=empty release, [1..NUM_LVL]=trigger levels, [TAB_N-1]=full
  logic [CNT_W-1:0] lvl_tab [TAB_N];
  assign lvl_tab[0]       = CNT_W'(1);
  assign lvl_tab[TAB_N-1] = CNT_W'(DEPTH);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign lvl_tab[g+1] = CNT_W'(trig_lvl(DEPTH, g));
  end

  logic [SEL_W:0]   idx;
  logic [CNT_W-1:0] lo, lvl, hi;
  logic             stop_q, irq_q;

  always_comb begin
    idx = {1'b0, sel_i};
    lo  = lvl_tab[idx];
    lvl = lvl_tab[idx + 1'b1];
    hi  = lvl_tab[idx + 2'd2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= en_i && (cnt_i >= lvl);
      if (!en_i)            stop_q <= 1'b0;
      else if (cnt_i >= hi) stop_q <= 1'b1;
      else if (cnt_i < lo)  stop_q <= 1'b0;
    end
  end

  assign rts_o = en_i ? stop_q : sw_rts_i;
  assign irq_o = irq_q;
endmodule

// File: rtl/uart_hs_cts.sv
module uart_hs_cts (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cts_i,
  input  logic boundary_i,
  output logic permit_o
);
  logic cts_s, permit_q;

  uart_hs_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cts_i),
    .q_o   (cts_s)
  );

  // re-evaluate only ahead of the next character load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         permit_q <= 1'b1;
    else if (!en_i)      permit_q <= 1'b1;
    else if (boundary_i) permit_q <= !cts_s;
  end

  assign permit_o = permit_q;
endmodule

// File: rtl/uart_hs_flow.sv
module uart_hs_flow
  import uart_hs_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_cts_en_i,
  input  logic             auto_rts_en_i,
  input  logic [SEL_W-1:0] trig_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             sw_rts_i,
  input  logic             cts_i,
  input  logic             tx_boundary_i,
  output logic             rts_o,
  output logic             tx_permit_o,
  output logic             rx_irq_o
);
  uart_hs_rts #(.DEPTH(DEPTH)) u_rts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (auto_rts_en_i),
    .sel_i   (trig_sel_i),
    .cnt_i   (rx_count_i),
    .sw_rts_i(sw_rts_i),
    .rts_o   (rts_o),
    .irq_o   (rx_irq_o)
  );

  uart_hs_cts u_cts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (auto_cts_en_i),
    .cts_i     (cts_i),
    .boundary_i(tx_boundary_i),
    .permit_o  (tx_permit_o)
  );
endmodule

// File: rtl/uart_hs_flow_chk.sv
module uart_hs_flow_chk
  import uart_hs_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             auto_cts_en_i,
  input logic             auto_rts_en_i,
  input logic [SEL_W-1:0] trig_sel_i,
  input logic [CNT_W-1:0] rx_count_i,
  input logic             sw_rts_i,
  input logic             cts_i,
  input logic             tx_boundary_i,
  input logic             rts_o,
  input logic             tx_permit_o,
  input logic             rx_irq_o
);
  logic [CNT_W-1:0] c_lvl, c_hi, c_lo;
  always_comb begin
    c_lvl = CNT_W'(trig_lvl(DEPTH, int'(trig_sel_i)));
    c_hi  = (trig_sel_i == 2'd3) ? CNT_W'(DEPTH) : CNT_W'(trig_lvl(DEPTH, int'(trig_sel_i) + 1));
    c_lo  = (trig_sel_i == 2'd0) ? CNT_W'(1) : CNT_W'(trig_lvl(DEPTH, int'(trig_sel_i) - 1));
  end

  p_irq_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && rx_count_i >= c_lvl) |=> rx_irq_o);

  p_irq_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_rts_en_i || rx_count_i < c_lvl) |=> !rx_irq_o);

  p_rts_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && rx_count_i >= c_hi) |=> (!auto_rts_en_i || rts_o));

  p_rts_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && rx_count_i < c_lo) |=> (!auto_rts_en_i || !rts_o));

  p_rts_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && rx_count_i >= c_lo && rx_count_i < c_hi)
      |=> (!auto_rts_en_i || rts_o == $past(rts_o)));

  p_rts_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_rts_en_i |=> (!auto_rts_en_i || !rts_o));

  p_permit_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_cts_en_i && !tx_boundary_i) |=> $stable(tx_permit_o));

  p_permit_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_cts_en_i |=> tx_permit_o);
endmodule

bind uart_hs_flow uart_hs_flow_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .auto_cts_en_i(auto_cts_en_i),
  .auto_rts_en_i(auto_rts_en_i),
  .trig_sel_i   (trig_sel_i),
  .rx_count_i   (rx_count_i),
  .sw_rts_i     (sw_rts_i),
  .cts_i        (cts_i),
  .tx_boundary_i(tx_boundary_i),
  .rts_o        (rts_o),
  .tx_permit_o  (tx_permit_o),
  .rx_irq_o     (rx_irq_o)
);

// File: tb/uart_hs_flow_tb_top.sv
`timescale 1ns/1ps
module uart_hs_flow_tb_top;
  localparam int DEPTH = 32;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_cts_en = 1'b0, auto_rts_en = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [CNT_W-1:0] rx_count = '0;
  logic sw_rts = 1'b0, cts = 1'b0, tx_boundary = 1'b0;
  logic rts, tx_permit, rx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_hs_flow #(.DEPTH(DEPTH)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .auto_cts_en_i(auto_cts_en),
    .auto_rts_en_i(auto_rts_en),
    .trig_sel_i   (trig_sel),
    .rx_count_i   (rx_count),
    .sw_rts_i     (sw_rts),
    .cts_i        (cts),
    .tx_boundary_i(tx_boundary),
    .rts_o        (rts),
    .tx_permit_o  (tx_permit),
    .rx_irq_o     (rx_irq)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int lvl_of(int s);
    int base = DEPTH / 8;
    return (s < 3) ? base * 2 * (s + 1) : base * 7;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, lo, lv, c;
    bit exp_stop;
    // R1 reset state
    repeat (2) tick();
    chk("R1 permit in reset", tx_permit, 1'b1);
    chk("R1 irq in reset", rx_irq, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R1 permit", tx_permit, 1'b1);
    chk("R1 irq", rx_irq, 1'b0);
    chk("R1 rts", rts, sw_rts);

    // R6 software RTS path, stop state cleared while disabled
    rx_count = CNT_W'(DEPTH);
    sw_rts = 1'b1; #1 chk("R6 sw rts 1", rts, 1'b1);
    tick(); chk("R3 irq with auto off", rx_irq, 1'b0);
    sw_rts = 1'b0; #1 chk("R6 sw rts 0", rts, 1'b0);
    tick();
    auto_rts_en = 1'b1; #1 chk("R6 stop cleared on enable", rts, 1'b0);
    tick(); chk("R4 full count stops", rts, 1'b1);
    auto_rts_en = 1'b0; rx_count = '0;
    tick();

    // R2..R5 sweep every select and every count, up then down
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      lv = lvl_of(s);
      hi = (s == 3) ? DEPTH : lvl_of(s + 1);
      lo = (s == 0) ? 1 : lvl_of(s - 1);
      auto_rts_en = 1'b1;
      exp_stop = 1'b0;
      for (int k = 0; k <= 2 * DEPTH + 1; k++) begin
        c = (k <= DEPTH) ? k : 2 * DEPTH + 1 - k;
        rx_count = CNT_W'(c);
        if (c >= hi) exp_stop = 1'b1;
        else if (c < lo) exp_stop = 1'b0;
        tick();
        if (c >= lv) chk("R2 irq set", rx_irq, 1'b1);
        else         chk("R3 irq clear", rx_irq, 1'b0);
        if (exp_stop) chk("R4 rts stop", rts, 1'b1);
        else          chk("R5 rts release", rts, 1'b0);
      end
      auto_rts_en = 1'b0;
      tick();
    end

    // CTS path
    auto_cts_en = 1'b1; cts = 1'b1;
    repeat (4) tick();
    chk("R9 no boundary, permit held", tx_permit, 1'b1);
    tx_boundary = 1'b1; tick(); tx_boundary = 1'b0;
    chk("R7 boundary stops", tx_permit, 1'b0);
    cts = 1'b0;
    repeat (4) tick();
    chk("R9 cts low, no boundary", tx_permit, 1'b0);
    tx_boundary = 1'b1; tick(); tx_boundary = 1'b0;
    chk("R7 boundary resumes", tx_permit, 1'b1);
    // latency with boundary held high
    cts = 1'b1; tx_boundary = 1'b1;
    tick(); chk("R7 edge1 not yet", tx_permit, 1'b1);
    tick(); chk("R7 edge2 not yet", tx_permit, 1'b1);
    tick(); chk("R7 edge3 stops", tx_permit, 1'b0);
    tx_boundary = 1'b0;
    // R8 disable forces permit
    auto_cts_en = 1'b0;
    tick(); chk("R8 disable permits", tx_permit, 1'b1);
    tick(); chk("R8 cts ignored", tx_permit, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule